// File: doc/BRIEF.md
# Link Authentication First-Phase Sequencer

This block drives the first phase of transmitter-side link authentication for a single display port. It seeds the cipher's random generator with two words and asks the cipher to capture a session value. It reads that 64-bit value back, low word first, and hands it to the bus side along with the transmitter's own public key. It then collects the receiver's 40-bit key and rejects it unless exactly half of its bits are set. It records whether the receiver is a repeater and, if so, programs the repeater control word for this port. Finally it enables authentication plus encryption.

After the key exchange the block waits a fixed minimum number of cycles, counted from the cycle the bus side accepted the value and key. Only then does it fetch the receiver's link-check value and load it into the cipher. It waits for the cipher to report a match and then active encryption, and signals hand-off to the repeater phase. A disable request tears the link down and waits for the cipher status to clear. Every failure parks the sequencer in an error state with a cause code until an abort returns it to idle. Bus transfers and the cipher itself are outside the block: they appear as request/response pins and a status word.

Top module: `link_auth_seq`

## Requirements
- R1: After reset the control word is 00, no request or write strobe is active, and done_o, err_o and err_code_o are all zero.
- R2: On start_i the block issues exactly two seed writes on consecutive cycles, each carrying the current rnd_i. In the next cycle it drives control 01, which is the capture request on bit 0.
- R3: The block then waits for status bit 17 (value ready). If the bit is not seen within AN_TO cycles, the block enters error with code 1.
- R4: The captured value is read low word first (val_sel_o=0), then high word (val_sel_o=1). It is presented as tx_value_o = {high, low} together with tx_key_o = own_key_i while tx_req_o is high.
- R5: A received key with exactly KEY_W/2 ones (20 of 40) is written out once on rkey_o with rkey_wr_o. Any other weight gives error code 2 and no key write.
- R6: When the receiver reports a repeater, one rep_wr_o pulse carries this port's present bit and a 3-bit port code at bits 22:20, while control is still 01. The per-port values are: port 0 → bit 29 / code 2; port 1 → bit 30 / code 1; port 2 → bit 28 / code 3; port 3 → bit 27 / code 4; port 4 → bit 25 / code 6. Without a repeater there is no such write.
- R7: Control becomes 11 (authenticate and encrypt) after the key and repeater steps and stays 11 through hand-off.
- R8: The check-value request is first raised exactly DELAY_CYC cycles after the cycle in which tx_ack_i was accepted, when all intermediate responses are immediate. It is never raised earlier.
- R9: The received check value is written once on chk_o with chk_wr_o. Status bit 19 (match) must then appear within MATCH_TO cycles, or the block enters error with code 3.
- R10: After a match, status bit 20 (encryption active) must appear within ENC_TO cycles, or the block enters error with code 4. On success done_o rises, and repeater_o reports the repeater flag.
- R11: disable_i in any active state drives control to 00. The block returns to idle once the whole status word reads zero within CLR_TO cycles; otherwise it enters error with code 5.
- R12: The error state and its code hold until abort_i, which returns the block to idle with code 0. abort_i has no effect in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin authentication from idle |
| disable_i | input | 1 | Tear down the link |
| abort_i | input | 1 | Leave the error state |
| rnd_i | input | 32 | Entropy word for seeding |
| seed_wr_o | output | 1 | Seed write strobe |
| seed_data_o | output | 32 | Seed word |
| ctrl_o | output | 2 | Cipher control (bit0 capture, 11 auth+encrypt) |
| status_i | input | 32 | Cipher status word |
| val_rd_o | output | 1 | Captured value read strobe |
| val_sel_o | output | 1 | 0 low word, 1 high word |
| val_data_i | input | 32 | Captured value word |
| own_key_i | input | 40 | Transmitter public key |
| tx_req_o | output | 1 | Send value and key to receiver |
| tx_value_o | output | 64 | Session value to send |
| tx_key_o | output | 40 | Public key to send |
| tx_ack_i | input | 1 | Send accepted |
| rkey_req_o | output | 1 | Request receiver key |
| rkey_valid_i | input | 1 | Receiver key valid |
| rkey_i | input | 40 | Receiver key |
| rkey_wr_o | output | 1 | Load accepted key into cipher |
| rkey_o | output | 40 | Accepted receiver key |
| rpt_req_o | output | 1 | Request repeater flag |
| rpt_valid_i | input | 1 | Repeater flag valid |
| rpt_i | input | 1 | Receiver is a repeater |
| rep_wr_o | output | 1 | Repeater control write |
| rep_word_o | output | 32 | Repeater control word |
| chk_req_o | output | 1 | Request receiver check value |
| chk_valid_i | input | 1 | Check value valid |
| chk_i | input | 16 | Receiver check value |
| chk_wr_o | output | 1 | Load check value into cipher |
| chk_o | output | 16 | Check value to cipher |
| done_o | output | 1 | First phase complete, hand off |
| repeater_o | output | 1 | Repeater flag at hand-off |
| err_o | output | 1 | Error state |
| err_code_o | output | 3 | Error cause |

## Verification
The main flow is run once with a direct receiver and once with a repeater, using two different balanced keys. These runs separate the repeater write and its port word from the plain path, and the cycle-exact gap from send to check request pins down the delay count. Keys of 19 and 21 ones check that the weight test is exact on both sides. Each status wait is stalled past its window and, for the match wait, satisfied on its final allowed cycle, which separates an off-by-one timeout from a correct one. Disable is driven both mid-flow and from hand-off, with status clearing and with a stuck bit. An abort during hand-off shows that it is ignored outside the error state.

// File: rtl/link_auth_pkg.sv
package link_auth_pkg;

   typedef enum logic [4:0] {
      S_IDLE, S_SEED0, S_SEED1, S_CAPT, S_AN_WAIT, S_RD_LO, S_RD_HI, S_SEND,
      S_KEY_REQ, S_KEY_LD, S_RPT_REQ, S_REP_WR, S_ENABLE, S_DELAY, S_CHK_REQ,
      S_CHK_LD, S_MATCH_WAIT, S_ENC_WAIT, S_HANDOFF, S_DISARM, S_ERROR
   } seq_state_t;

   typedef enum logic [2:0] {
      ERR_NONE     = 3'd0,
      ERR_VALUE_TO = 3'd1,
      ERR_BAD_KEY  = 3'd2,
      ERR_MATCH_TO = 3'd3,
      ERR_ENC_TO   = 3'd4,
      ERR_CLEAR_TO = 3'd5
   } err_t;

   localparam int ST_VALUE_RDY = 17;
   localparam int ST_MATCH     = 19;
   localparam int ST_ENC       = 20;

   localparam logic [1:0] CTL_OFF      = 2'b00;
   localparam logic [1:0] CTL_CAPTURE  = 2'b01;
   localparam logic [1:0] CTL_AUTH_ENC = 2'b11;

   // repeater control word for a port: present flag plus port code at 22:20
   function automatic logic [31:0] rep_word(input int unsigned p);
      logic [31:0] w;
      w = '0;
      case (p)
         0:       begin w[29] = 1'b1; w[22:20] = 3'd2; end
         1:       begin w[30] = 1'b1; w[22:20] = 3'd1; end
         2:       begin w[28] = 1'b1; w[22:20] = 3'd3; end
         3:       begin w[27] = 1'b1; w[22:20] = 3'd4; end
         default: begin w[25] = 1'b1; w[22:20] = 3'd6; end
      endcase
      return w;
   endfunction

endpackage

// File: rtl/link_auth_weight.sv
module link_auth_weight #(
   parameter int W      = 40,
   parameter int TARGET = 20
) (
   input  logic [W-1:0] vec_i,
   output logic         ok_o
);
   localparam int CW = $clog2(W + 1);

   if (TARGET > W) begin : g_bad_target
      $error("TARGET exceeds vector width");
   end

   logic [CW-1:0] ones;

   always_comb begin
      ones = '0;
      for (int i = 0; i < W; i++) begin
         ones = ones + CW'(vec_i[i]);
      end
   end

   assign ok_o = (ones == CW'(TARGET));

endmodule

// File: rtl/link_auth_cnt.sv
module link_auth_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);
   if (W < 2) begin : g_bad_width
      $error("counter width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else if (cnt_o != '1) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && cnt_o != '0) |=> (cnt_o != '0)); // R8

endmodule

// File: rtl/link_auth_seq.sv
module link_auth_seq
   import link_auth_pkg::*;
#(
   parameter int KEY_W     = 40,
   parameter int WORD_W    = 32,
   parameter int CHK_W     = 16,
   parameter int STAT_W    = 32,
   parameter int PORT_SEL  = 0,
   parameter int DELAY_CYC = 30_000_000,
   parameter int AN_TO     = 100_000,
   parameter int MATCH_TO  = 100_000,
   parameter int ENC_TO    = 2_000_000,
   parameter int CLR_TO    = 2_000_000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                disable_i,
   input  logic                abort_i,
   input  logic [WORD_W-1:0]   rnd_i,
   output logic                seed_wr_o,
   output logic [WORD_W-1:0]   seed_data_o,
   output logic [1:0]          ctrl_o,
   input  logic [STAT_W-1:0]   status_i,
   output logic                val_rd_o,
   output logic                val_sel_o,
   input  logic [WORD_W-1:0]   val_data_i,
   input  logic [KEY_W-1:0]    own_key_i,
   output logic                tx_req_o,
   output logic [2*WORD_W-1:0] tx_value_o,
   output logic [KEY_W-1:0]    tx_key_o,
   input  logic                tx_ack_i,
   output logic                rkey_req_o,
   input  logic                rkey_valid_i,
   input  logic [KEY_W-1:0]    rkey_i,
   output logic                rkey_wr_o,
   output logic [KEY_W-1:0]    rkey_o,
   output logic                rpt_req_o,
   input  logic                rpt_valid_i,
   input  logic                rpt_i,
   output logic                rep_wr_o,
   output logic [31:0]         rep_word_o,
   output logic                chk_req_o,
   input  logic                chk_valid_i,
   input  logic [CHK_W-1:0]    chk_i,
   output logic                chk_wr_o,
   output logic [CHK_W-1:0]    chk_o,
   output logic                done_o,
   output logic                repeater_o,
   output logic                err_o,
   output logic [2:0]          err_code_o
);
   localparam int MAX_AB   = (AN_TO > MATCH_TO) ? AN_TO : MATCH_TO;
   localparam int MAX_CD   = (ENC_TO > CLR_TO) ? ENC_TO : CLR_TO;
   localparam int MAX_TO   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int WAIT_W   = $clog2(MAX_TO + 1) + 1;
   localparam int DLY_W    = $clog2(DELAY_CYC + 1) + 1;
   localparam int KEY_ONES = KEY_W / 2;
   localparam logic [31:0] REP_WORD = rep_word(PORT_SEL);
   localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYC - 2);

   // elaboration-time parameter checks
   if (PORT_SEL < 0 || PORT_SEL > 4) begin : g_bad_port
      $error("PORT_SEL must be 0..4");
   end
   if (DELAY_CYC < 8) begin : g_bad_delay
      $error("DELAY_CYC must be at least 8");
   end
   if (AN_TO < 1 || MATCH_TO < 1 || ENC_TO < 1 || CLR_TO < 1) begin : g_bad_to
      $error("timeouts must be at least one cycle");
   end
   if (STAT_W <= ST_ENC) begin : g_bad_stat
      $error("status word too narrow");
   end
   if ((KEY_W % 2) != 0) begin : g_bad_key
      $error("KEY_W must be even");
   end

   seq_state_t state_q, state_d;
   err_t       err_q, err_d;

   logic [WORD_W-1:0] val_lo_q, val_hi_q;
   logic [KEY_W-1:0]  rkey_q;
   logic [CHK_W-1:0]  chk_q;
   logic              rpt_q;

   logic [WAIT_W-1:0] wt_cnt, wt_last;
   logic [DLY_W-1:0]  dly_cnt;
   logic              wt_exp, dly_done, key_ok, dly_clr, wt_clr;

   // ---------------- helpers ----------------
   link_auth_weight #(.W(KEY_W), .TARGET(KEY_ONES)) u_weight (
      .vec_i (rkey_i),
      .ok_o  (key_ok)
   );

   assign wt_clr = (state_d != state_q);

   link_auth_cnt #(.W(WAIT_W)) u_wait_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (wt_clr),
      .cnt_o (wt_cnt)
   );

   assign dly_clr = (state_q == S_SEND) && tx_ack_i;

   link_auth_cnt #(.W(DLY_W)) u_delay_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (dly_clr),
      .cnt_o (dly_cnt)
   );

   always_comb begin
      case (state_q)
         S_AN_WAIT:    wt_last = WAIT_W'(AN_TO - 1);
         S_MATCH_WAIT: wt_last = WAIT_W'(MATCH_TO - 1);
         S_ENC_WAIT:   wt_last = WAIT_W'(ENC_TO - 1);
         S_DISARM:     wt_last = WAIT_W'(CLR_TO - 1);
         default:      wt_last = '1;
      endcase
   end

   assign wt_exp   = (wt_cnt >= wt_last);
   assign dly_done = (dly_cnt >= DLY_LAST);

   // ---------------- sequencing ----------------
   always_comb begin
      state_d = state_q;
      err_d   = err_q;
      case (state_q)
         S_IDLE:    if (start_i) state_d = S_SEED0;
         S_SEED0:   state_d = S_SEED1;
         S_SEED1:   state_d = S_CAPT;
         S_CAPT:    state_d = S_AN_WAIT;
         S_AN_WAIT: begin
            if (status_i[ST_VALUE_RDY]) begin
               state_d = S_RD_LO;
            end else if (wt_exp) begin
               state_d = S_ERROR;
               err_d   = ERR_VALUE_TO;
            end
         end
         S_RD_LO:   state_d = S_RD_HI;
         S_RD_HI:   state_d = S_SEND;
         S_SEND:    if (tx_ack_i) state_d = S_KEY_REQ;
         S_KEY_REQ: begin
            if (rkey_valid_i) begin
               if (key_ok) begin
                  state_d = S_KEY_LD;
               end else begin
                  state_d = S_ERROR;
                  err_d   = ERR_BAD_KEY;
               end
            end
         end
         S_KEY_LD:  state_d = S_RPT_REQ;
         S_RPT_REQ: if (rpt_valid_i) state_d = rpt_i ? S_REP_WR : S_ENABLE;
         S_REP_WR:  state_d = S_ENABLE;
         S_ENABLE:  state_d = S_DELAY;
         S_DELAY:   if (dly_done) state_d = S_CHK_REQ;
         S_CHK_REQ: if (chk_valid_i) state_d = S_CHK_LD;
         S_CHK_LD:  state_d = S_MATCH_WAIT;
         S_MATCH_WAIT: begin
            if (status_i[ST_MATCH]) begin
               state_d = S_ENC_WAIT;
            end else if (wt_exp) begin
               state_d = S_ERROR;
               err_d   = ERR_MATCH_TO;
            end
         end
         S_ENC_WAIT: begin
            if (status_i[ST_ENC]) begin
               state_d = S_HANDOFF;
            end else if (wt_exp) begin
               state_d = S_ERROR;
               err_d   = ERR_ENC_TO;
            end
         end
         S_HANDOFF: state_d = S_HANDOFF;
         S_DISARM: begin
            if (status_i == '0) begin
               state_d = S_IDLE;
            end else if (wt_exp) begin
               state_d = S_ERROR;
               err_d   = ERR_CLEAR_TO;
            end
         end
         S_ERROR: begin
            if (abort_i) begin
               state_d = S_IDLE;
               err_d   = ERR_NONE;
            end
         end
         default:   state_d = S_IDLE;
      endcase

      // teardown wins over any step of an active run
      if (disable_i && !(state_q inside {S_IDLE, S_DISARM, S_ERROR})) begin
         state_d = S_DISARM;
         err_d   = err_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         err_q   <= ERR_NONE;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
      end
   end

   // ---------------- captured data ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_lo_q <= '0;
         val_hi_q <= '0;
         rkey_q   <= '0;
         chk_q    <= '0;
         rpt_q    <= 1'b0;
      end else begin
         if (state_q == S_RD_LO) val_lo_q <= val_data_i;
         if (state_q == S_RD_HI) val_hi_q <= val_data_i;
         if (state_q == S_KEY_REQ && rkey_valid_i && key_ok) rkey_q <= rkey_i;
         if (state_q == S_RPT_REQ && rpt_valid_i) rpt_q <= rpt_i;
         if (state_q == S_CHK_REQ && chk_valid_i) chk_q <= chk_i;
      end
   end

   // ---------------- outputs ----------------
   always_comb begin
      case (state_q)
         S_CAPT, S_AN_WAIT, S_RD_LO, S_RD_HI, S_SEND, S_KEY_REQ, S_KEY_LD,
         S_RPT_REQ, S_REP_WR:
            ctrl_o = CTL_CAPTURE;
         S_ENABLE, S_DELAY, S_CHK_REQ, S_CHK_LD, S_MATCH_WAIT, S_ENC_WAIT,
         S_HANDOFF:
            ctrl_o = CTL_AUTH_ENC;
         default:
            ctrl_o = CTL_OFF;
      endcase
   end

   assign seed_wr_o   = (state_q == S_SEED0) || (state_q == S_SEED1);
   assign seed_data_o = rnd_i;
   assign val_rd_o    = (state_q == S_RD_LO) || (state_q == S_RD_HI);
   assign val_sel_o   = (state_q == S_RD_HI);
   assign tx_req_o    = (state_q == S_SEND);
   assign tx_value_o  = {val_hi_q, val_lo_q};
   assign tx_key_o    = own_key_i;
   assign rkey_req_o  = (state_q == S_KEY_REQ);
   assign rkey_wr_o   = (state_q == S_KEY_LD);
   assign rkey_o      = rkey_q;
   assign rpt_req_o   = (state_q == S_RPT_REQ);
   assign rep_wr_o    = (state_q == S_REP_WR);
   assign rep_word_o  = REP_WORD;
   assign chk_req_o   = (state_q == S_CHK_REQ);
   assign chk_wr_o    = (state_q == S_CHK_LD);
   assign chk_o       = chk_q;
   assign done_o      = (state_q == S_HANDOFF);
   assign repeater_o  = (state_q == S_HANDOFF) && rpt_q;
   assign err_o       = (state_q == S_ERROR);
   assign err_code_o  = err_q;

   // ---------------- assertions ----------------
   AST_SEED_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o == CTL_CAPTURE && $past(ctrl_o) == CTL_OFF) |-> $past(seed_wr_o)); // R2

   AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (val_rd_o && val_sel_o) |-> $past(val_rd_o && !val_sel_o)); // R4

   AST_KEY_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
      rkey_wr_o |-> ($countones(rkey_o) == KEY_ONES)); // R5

   AST_REP_THEN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_wr_o && !disable_i) |=> (ctrl_o == CTL_AUTH_ENC)); // R6

   AST_CHECK_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req_o |-> dly_done); // R8

   AST_DONE_AFTER_ENC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(status_i[ST_ENC])); // R10

   AST_DISARM_CTRL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && disable_i) |=> (ctrl_o == CTL_OFF)); // R11

   AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !abort_i) |=> (err_o && $stable(err_code_o))); // R12

endmodule

// File: tb/link_auth_seq_bench.sv
module link_auth_seq_bench;
   localparam int DLY  = 40;
   localparam int ANT  = 8;
   localparam int MT   = 10;
   localparam int ET   = 12;
   localparam int CT   = 6;
   localparam logic [31:0] VLO  = 32'h1234_5678;
   localparam logic [31:0] VHI  = 32'hCAFE_0001;
   localparam logic [39:0] OWNK = 40'h0F_0F0F_0F0F;
   localparam logic [15:0] CHKV = 16'hBEEF;
   localparam logic [31:0] REPW = 32'h1030_0000; // port 2: bit 28, code 3

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, disable_i = 1'b0, abort_i = 1'b0;
   logic [31:0] rnd_i = 32'h0101_0101;
   logic seed_wr_o, val_rd_o, val_sel_o, tx_req_o, tx_ack_i;
   logic [31:0] seed_data_o, val_data_i, status_i, rep_word_o;
   logic [1:0] ctrl_o;
   logic [63:0] tx_value_o;
   logic [39:0] tx_key_o, rkey_o;
   logic [39:0] rkey_v = 40'h00_000F_FFFF;
   logic rkey_req_o, rkey_valid_i, rkey_wr_o, rpt_req_o, rpt_valid_i;
   logic rpt_v = 1'b0;
   logic rep_wr_o, chk_req_o, chk_valid_i, chk_wr_o, done_o, repeater_o, err_o;
   logic [15:0] chk_o;
   logic [2:0] err_code_o;
   logic an_auto = 1'b1, match_f = 1'b0, enc_f = 1'b0, stuck_f = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;
   always @(posedge clk) rnd_i <= rnd_i + 32'h1111_1111;

   // cipher and receiver models
   assign val_data_i  = val_sel_o ? VHI : VLO;
   assign tx_ack_i    = tx_req_o;
   assign rkey_valid_i = rkey_req_o;
   assign rpt_valid_i = rpt_req_o;
   assign chk_valid_i = chk_req_o;
   assign status_i = {11'b0, enc_f, match_f, 1'b0, an_auto & (ctrl_o == 2'b01),
                      stuck_f, 16'b0};

   link_auth_seq #(
      .PORT_SEL(2), .DELAY_CYC(DLY), .AN_TO(ANT), .MATCH_TO(MT),
      .ENC_TO(ET), .CLR_TO(CT)
   ) u_link_auth_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .disable_i(disable_i),
      .abort_i(abort_i), .rnd_i(rnd_i), .seed_wr_o(seed_wr_o),
      .seed_data_o(seed_data_o), .ctrl_o(ctrl_o), .status_i(status_i),
      .val_rd_o(val_rd_o), .val_sel_o(val_sel_o), .val_data_i(val_data_i),
      .own_key_i(OWNK), .tx_req_o(tx_req_o), .tx_value_o(tx_value_o),
      .tx_key_o(tx_key_o), .tx_ack_i(tx_ack_i), .rkey_req_o(rkey_req_o),
      .rkey_valid_i(rkey_valid_i), .rkey_i(rkey_v), .rkey_wr_o(rkey_wr_o),
      .rkey_o(rkey_o), .rpt_req_o(rpt_req_o), .rpt_valid_i(rpt_valid_i),
      .rpt_i(rpt_v), .rep_wr_o(rep_wr_o), .rep_word_o(rep_word_o),
      .chk_req_o(chk_req_o), .chk_valid_i(chk_valid_i), .chk_i(CHKV),
      .chk_wr_o(chk_wr_o), .chk_o(chk_o), .done_o(done_o),
      .repeater_o(repeater_o), .err_o(err_o), .err_code_o(err_code_o)
   );

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic to_chk_wr();
      for (int i = 0; i < 300 && !chk_wr_o; i++) @(negedge clk);
   endtask

   task automatic recover();
      abort_i = 1'b1;
      @(negedge clk) abort_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 ctrl", ctrl_o, 2'b00);
      check("R1 strobes", {seed_wr_o, tx_req_o, rkey_req_o, chk_req_o, rep_wr_o}, 0);
      check("R1 done/err/code", {done_o, err_o, err_code_o}, 0);
   endtask

   task automatic t_flow(input logic [39:0] k, input logic rp);
      int n, rk_seen, rep_seen;
      logic [39:0] rk_val;
      logic [31:0] rep_val;
      logic [1:0] rep_ctl;
      rkey_v = k; rpt_v = rp; an_auto = 1'b1; match_f = 1'b1; enc_f = 1'b1;
      pulse_start();
      check("R2 seed write 1", {seed_wr_o, seed_data_o}, {1'b1, rnd_i});
      @(negedge clk);
      check("R2 seed write 2", {seed_wr_o, seed_data_o}, {1'b1, rnd_i});
      @(negedge clk);
      check("R2 capture after seeds", {seed_wr_o, ctrl_o}, {1'b0, 2'b01});
      for (int i = 0; i < 50 && !val_rd_o; i++) @(negedge clk);
      check("R4 low word first", {val_rd_o, val_sel_o}, 2'b10);
      @(negedge clk);
      check("R4 high word second", {val_rd_o, val_sel_o}, 2'b11);
      for (int i = 0; i < 50 && !tx_req_o; i++) @(negedge clk);
      check("R4 tx value", tx_value_o, {VHI, VLO});
      check("R4 tx key", tx_key_o, OWNK);
      n = 0; rk_seen = 0; rep_seen = 0; rk_val = '0; rep_val = '0; rep_ctl = '0;
      while (n < 400) begin
         @(negedge clk);
         n++;
         if (rkey_wr_o) begin rk_seen++; rk_val = rkey_o; end
         if (rep_wr_o) begin rep_seen++; rep_val = rep_word_o; rep_ctl = ctrl_o; end
         if (chk_req_o) break;
      end
      check("R8 delay to check request", n, DLY);
      check("R5 balanced key written once", {rk_seen[7:0], rk_val}, {8'd1, k});
      check("R6 repeater writes", rep_seen, rp ? 1 : 0);
      if (rp) check("R6 repeater word and ctrl", {rep_val, rep_ctl}, {REPW, 2'b01});
      check("R7 ctrl auth+enc", ctrl_o, 2'b11);
      @(negedge clk);
      check("R9 check value load", {chk_wr_o, chk_o}, {1'b1, CHKV});
      for (int i = 0; i < 10 && !done_o; i++) @(negedge clk);
      check("R10 done and repeater flag", {done_o, repeater_o, err_o}, {1'b1, rp, 1'b0});
      check("R7 ctrl held at handoff", ctrl_o, 2'b11);
   endtask

   task automatic t_abort_ignored();
      recover();
      repeat (3) @(negedge clk);
      check("R12 abort ignored outside error", {done_o, ctrl_o, err_o}, {1'b1, 2'b11, 1'b0});
   endtask

   task automatic t_disable_clean();
      int n;
      @(negedge clk) disable_i = 1'b1;
      @(negedge clk) disable_i = 1'b0;
      check("R11 ctrl off on disable", {ctrl_o, done_o}, {2'b00, 1'b0});
      @(negedge clk);
      match_f = 1'b0; enc_f = 1'b0;
      n = 0;
      for (int i = 0; i < 20 && !(ctrl_o == 2'b00 && !err_o && n > 0); i++) begin
         @(negedge clk); n++;
      end
      check("R11 back to idle", {err_o, err_code_o, done_o}, 0);
      pulse_start();
      check("R11 restart from idle", seed_wr_o, 1'b1);
      @(negedge clk) disable_i = 1'b1;
      @(negedge clk) disable_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R11 idle after mid-run disable", {ctrl_o, err_o, seed_wr_o}, 0);
   endtask

   task automatic t_disable_stuck();
      int n;
      t_flow(40'hA5_A5A5_A5A5, 1'b0);
      stuck_f = 1'b1;
      @(negedge clk) disable_i = 1'b1;
      n = 0;
      @(negedge clk) begin disable_i = 1'b0; match_f = 1'b0; enc_f = 1'b0; end
      n = 1;
      while (!err_o && n < 50) begin @(negedge clk); n++; end
      check("R11 clear timeout cycles", n, CT + 1);
      check("R11 clear timeout code", err_code_o, 3'd5);
      stuck_f = 1'b0;
      repeat (4) @(negedge clk);
      check("R12 error holds", {err_o, err_code_o}, {1'b1, 3'd5});
      recover();
      check("R12 abort returns idle", {err_o, err_code_o, ctrl_o}, 0);
   endtask

   task automatic t_value_timeout();
      int n;
      an_auto = 1'b0;
      pulse_start();
      for (int i = 0; i < 10 && ctrl_o != 2'b01; i++) @(negedge clk);
      n = 0;
      while (!err_o && n < 50) begin @(negedge clk); n++; end
      check("R3 value wait cycles", n, ANT + 1);
      check("R3 value timeout code", {err_code_o, ctrl_o}, {3'd1, 2'b00});
      recover();
      an_auto = 1'b1;
   endtask

   task automatic t_bad_key(input logic [39:0] k, input string tag);
      int wr;
      rkey_v = k; wr = 0;
      pulse_start();
      for (int i = 0; i < 60 && !err_o; i++) begin
         @(negedge clk);
         if (rkey_wr_o) wr++;
      end
      check(tag, {err_o, err_code_o, wr[7:0]}, {1'b1, 3'd2, 8'd0});
      recover();
   endtask

   task automatic t_match_timeout();
      int n;
      rkey_v = 40'h00_000F_FFFF; rpt_v = 1'b0; match_f = 1'b0; enc_f = 1'b1;
      pulse_start();
      to_chk_wr();
      n = 0;
      while (!err_o && n < 50) begin @(negedge clk); n++; end
      check("R9 match wait cycles", n, MT + 1);
      check("R9 match timeout code", err_code_o, 3'd3);
      recover();
   endtask

   task automatic t_match_last_cycle();
      pulse_start();
      to_chk_wr();
      repeat (MT) @(negedge clk);
      match_f = 1'b1;
      for (int i = 0; i < 5 && !done_o; i++) @(negedge clk);
      check("R9 match on last allowed cycle", {done_o, err_o}, 2'b10);
      @(negedge clk) disable_i = 1'b1;
      @(negedge clk) begin disable_i = 1'b0; match_f = 1'b0; enc_f = 1'b0; end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_enc_timeout();
      int n;
      match_f = 1'b1; enc_f = 1'b0;
      pulse_start();
      to_chk_wr();
      n = 0;
      while (!err_o && n < 50) begin @(negedge clk); n++; end
      check("R10 encryption wait cycles", n, ET + 2);
      check("R10 encryption timeout code", {err_code_o, done_o}, {3'd4, 1'b0});
      match_f = 1'b0;
      recover();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_flow(40'h00_000F_FFFF, 1'b0);
      t_abort_ignored();
      t_disable_clean();
      t_flow(40'hA5_A5A5_A5A5, 1'b1);
      t_disable_clean();
      t_disable_stuck();
      t_value_timeout();
      t_bad_key(40'h00_0007_FFFF, "R5 key with 19 ones rejected");
      t_bad_key(40'h00_001F_FFFF, "R5 key with 21 ones rejected");
      t_match_timeout();
      t_match_last_cycle();
      t_enc_timeout();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100_000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule